// File: doc/BRIEF.md
# Sparse Descriptor Register Loader

This block fills a transfer channel's register file from a compact command descriptor held in memory. A descriptor starts with a 32-bit header word. Each set header bit picks one channel register. The words that follow the header carry values only for the picked registers, and they are laid out from the lowest picked bit to the highest. The loader fetches the words one at a time over a single-beat read port, writes each value into its register, and then pulses a channel-enable strobe. The data-moving engine itself sits outside this block.

Once the channel reports completion, the loader looks at bit 0 of the loaded link-address register. If that bit is set, it fetches the next descriptor from the link address, with the two low bits masked off, and repeats the cycle. If the bit is clear, it goes idle. Any read error during a fetch abandons the descriptor, raises a sticky error flag and never starts the channel. The register file can be read back through a select port. Three fields of the control register are also decoded onto dedicated outputs for the engine.

Top module: `desc_loader`

## Requirements
- R1: Header bits 2..12, 14, 19, 20, 29, 30 and 31 each select one register. Register index equals bit position: bit 3 is control, bit 30 is link low, bit 31 is link high. Each set selecting bit consumes exactly one payload word. The other bits (1, 13, 15..18, 21..28) consume no word, and their register slots always read zero.
- R2: The header is read at the start address. Payload words are read at consecutive word addresses (+4 bytes each), in ascending order of the selecting header bits.
- R3: Header bit 0 clears every register to zero before any payload is written. A header with only bit 0 set reads no payload word.
- R4: Registers whose bits are not set in the header keep their previous value.
- R5: After the last payload word, `ch_enable_o` pulses high for exactly one cycle. A header with no selecting bits still gives exactly one pulse.
- R6: After the pulse, no word is fetched until `ch_done_i`. On done, if bit 0 of link low is 1, the next header is fetched from {link high, link low} truncated to the address width, with bits 1:0 cleared. Otherwise `busy_o` falls.
- R7: A response with `mem_rsp_err_i` high aborts the descriptor. It sets `err_o`, gives no `ch_enable_o` pulse and returns to idle. Registers already written keep their values. The next start clears `err_o`.
- R8: `cfg_data_o` shows register `cfg_sel_i` one cycle after the select is applied. After reset, every register and every output is zero.
- R9: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address hold stable.
- R10: `elem_size_o` = control[2:0], `xfer_mode_o` = control[11:9] (0 off, 1 continue, 2 wrap, 3 fill), and `done_mode_o` = control[23:21] (0 none, 1 end of command, 3 end of cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin loading at start_addr_i (used when idle) |
| start_addr_i | input | AW | Byte address of the first header |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | AW | Read request byte address |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read response word |
| mem_rsp_err_i | input | 1 | Read response error |
| ch_enable_o | output | 1 | One-cycle channel start strobe |
| ch_done_i | input | 1 | Channel finished its command |
| busy_o | output | 1 | Loader active or channel running |
| err_o | output | 1 | Sticky fetch error flag |
| cfg_sel_i | input | 5 | Register index to read back |
| cfg_data_o | output | 32 | Registered read-back value |
| elem_size_o | output | 3 | Element size field of control |
| xfer_mode_o | output | 3 | Transfer type field of control |
| done_mode_o | output | 3 | Completion type field of control |

## Verification
The in-line properties watch four things on every cycle. The fetch request holds while stalled. The start strobe lasts one cycle and never coincides with the error flag. No fetch follows a launch directly. A register write never lands on a non-register slot or in the same cycle as a clear. The bench scenarios cover what only a whole descriptor can show. These are the sparse word-to-register mapping over several headers, clear-then-load ordering, the exact word count per header, chaining to a masked link address only after done, and abort with partial register state on a read error.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int WORD_W   = 32;
  localparam int NREG     = 32;
  localparam int IDX_W    = $clog2(NREG);
  localparam logic [NREG-1:0] REG_MASK = 32'hE018_5FFC;
  localparam int CLR_BIT  = 0;
  localparam int CTRL_BIT = 3;
  localparam int LINK_LO  = 30;
  localparam int LINK_HI  = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_HREQ, S_HRSP, S_WREQ, S_WRSP, S_GO, S_RUN
  } ld_state_e;

  typedef enum logic [2:0] {
    XM_OFF = 3'd0, XM_CONT = 3'd1, XM_WRAP = 3'd2, XM_FILL = 3'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    DM_NONE = 3'd0, DM_CMD = 3'd1, DM_CYCLE = 3'd3
  } done_mode_e;
endpackage

// File: rtl/dl_bitpick.sv
module dl_bitpick #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [W-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  assign oh_o  = vec_i & (~vec_i + W'(1));
  assign any_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (oh_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dl_regfile.sv
module dl_regfile
  import dl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] link_lo_o,
  output logic [WORD_W-1:0] link_hi_o
);
  logic [WORD_W-1:0] rv [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (REG_MASK[g]) begin : g_impl
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst || clr_i) q <= '0;
        else if (wr_en_i && wr_idx_i == IDX_W'(g)) q <= wr_data_i;
      end
      assign rv[g] = q;
    end else begin : g_none
      assign rv[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rv[rd_sel_i];
  end

  assign ctrl_o    = rv[CTRL_BIT];
  assign link_lo_o = rv[LINK_LO];
  assign link_hi_o = rv[LINK_HI];

  // R1
  wr_impl_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> REG_MASK[wr_idx_i]);

  // R3
  clr_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |-> !wr_en_i);
endmodule

// File: rtl/dl_seq.sv
module dl_seq
  import dl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [AW-1:0]     start_addr_i,
  output logic              mem_req_valid_o,
  output logic [AW-1:0]     mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  input  logic              mem_rsp_err_i,
  input  logic [WORD_W-1:0] link_lo_i,
  input  logic [WORD_W-1:0] link_hi_i,
  input  logic              ch_done_i,
  output logic              ch_enable_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              clr_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [WORD_W-1:0] wr_data_o
);
  ld_state_e         state;
  logic [AW-1:0]     addr_q;
  logic [NREG-1:0]   pend_q;
  logic [IDX_W-1:0]  widx_q;
  logic              err_q;

  logic [NREG-1:0]   pick_oh;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;

  logic [2*WORD_W-1:0] link_full;
  logic [NREG-1:0]     hdr_sel;
  logic [NREG-1:0]     pend_nx;
  logic                rsp_ok;
  logic                rsp_bad;
  logic                unused_link;

  dl_bitpick #(.W(NREG)) u_pick (
    .vec_i (pend_q),
    .oh_o  (pick_oh),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  assign link_full   = {link_hi_i, link_lo_i};
  assign unused_link = ^link_full;
  assign hdr_sel     = mem_rsp_data_i & REG_MASK;
  assign pend_nx     = pend_q & ~pick_oh;
  assign rsp_ok      = mem_rsp_valid_i && !mem_rsp_err_i;
  assign rsp_bad     = mem_rsp_valid_i && mem_rsp_err_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      addr_q <= '0;
      pend_q <= '0;
      widx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          addr_q <= start_addr_i;
          err_q  <= 1'b0;
          state  <= S_HREQ;
        end
        S_HREQ: if (mem_req_ready_i) state <= S_HRSP;
        S_HRSP: begin
          if (rsp_bad) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (rsp_ok) begin
            pend_q <= hdr_sel;
            addr_q <= addr_q + AW'(4);
            state  <= (|hdr_sel) ? S_WREQ : S_GO;
          end
        end
        S_WREQ: if (mem_req_ready_i) begin
          widx_q <= pick_idx;
          state  <= S_WRSP;
        end
        S_WRSP: begin
          if (rsp_bad) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (rsp_ok) begin
            pend_q <= pend_nx;
            addr_q <= addr_q + AW'(4);
            state  <= (|pend_nx) ? S_WREQ : S_GO;
          end
        end
        S_GO: state <= S_RUN;
        S_RUN: if (ch_done_i) begin
          if (link_lo_i[0]) begin
            addr_q <= {link_full[AW-1:2], 2'b00};
            state  <= S_HREQ;
          end else begin
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state == S_HREQ) || (state == S_WREQ);
  assign mem_req_addr_o  = addr_q;
  assign ch_enable_o     = (state == S_GO);
  assign busy_o          = (state != S_IDLE);
  assign err_o           = err_q;
  assign clr_o           = (state == S_HRSP) && rsp_ok && mem_rsp_data_i[CLR_BIT];
  assign wr_en_o         = (state == S_WRSP) && rsp_ok;
  assign wr_idx_o        = widx_q;
  assign wr_data_o       = mem_rsp_data_i;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R5
  en_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ch_enable_o |=> !ch_enable_o);

  // R7
  err_noen_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !ch_enable_o);

  // R6
  launch_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
    ch_enable_o |=> !mem_req_valid_o);

  // R2
  pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_oh) && (pick_any == (pend_q != '0)));
endmodule

// File: rtl/desc_loader.sv
module desc_loader
  import dl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [AW-1:0]     start_addr_i,
  output logic              mem_req_valid_o,
  output logic [AW-1:0]     mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_data_i,
  input  logic              mem_rsp_err_i,
  output logic              ch_enable_o,
  input  logic              ch_done_i,
  output logic              busy_o,
  output logic              err_o,
  input  logic [4:0]        cfg_sel_i,
  output logic [31:0]       cfg_data_o,
  output logic [2:0]        elem_size_o,
  output logic [2:0]        xfer_mode_o,
  output logic [2:0]        done_mode_o
);
  logic              clr;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] ctrl;
  logic [WORD_W-1:0] link_lo;
  logic [WORD_W-1:0] link_hi;
  logic              unused_ctrl;

  dl_seq #(.AW(AW)) u_seq (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .start_addr_i    (start_addr_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_rsp_err_i   (mem_rsp_err_i),
    .link_lo_i       (link_lo),
    .link_hi_i       (link_hi),
    .ch_done_i       (ch_done_i),
    .ch_enable_o     (ch_enable_o),
    .busy_o          (busy_o),
    .err_o           (err_o),
    .clr_o           (clr),
    .wr_en_o         (wr_en),
    .wr_idx_o        (wr_idx),
    .wr_data_o       (wr_data)
  );

  dl_regfile u_regs (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_sel_i  (cfg_sel_i),
    .rd_data_o (cfg_data_o),
    .ctrl_o    (ctrl),
    .link_lo_o (link_lo),
    .link_hi_o (link_hi)
  );

  assign elem_size_o = ctrl[2:0];
  assign xfer_mode_o = ctrl[11:9];
  assign done_mode_o = ctrl[23:21];
  assign unused_ctrl = ^ctrl;
endmodule

// File: tb/sim_desc_loader.sv
module sim_desc_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_err = 1'b0;
  logic        ch_enable;
  logic        ch_done = 1'b0;
  logic        busy;
  logic        err;
  logic [4:0]  cfg_sel = '0;
  logic [31:0] cfg_data;
  logic [2:0]  elem_size, xfer_mode, done_mode;

  always #2.5 clk = ~clk;

  desc_loader #(.AW(32)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .start_addr_i(start_addr),
    .mem_req_valid_o(req_valid), .mem_req_addr_o(req_addr), .mem_req_ready_i(req_ready),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .mem_rsp_err_i(rsp_err),
    .ch_enable_o(ch_enable), .ch_done_i(ch_done), .busy_o(busy), .err_o(err),
    .cfg_sel_i(cfg_sel), .cfg_data_o(cfg_data),
    .elem_size_o(elem_size), .xfer_mode_o(xfer_mode), .done_mode_o(done_mode)
  );

  localparam logic [31:0] REGS = 32'hE018_5FFC;
  localparam int NV = 6;
  localparam logic [31:0] VHDR  [NV] = '{32'h0000_0008, 32'hE018_5FFC, 32'h0000_0051,
                                         32'h0002_A050, 32'h0000_0001, 32'h0000_0000};
  localparam logic [31:0] VSEED [NV] = '{32'h1000, 32'h2000, 32'h3000,
                                         32'h4000, 32'h5000, 32'h6000};

  logic [31:0] mem [256];
  logic [31:0] expr [32];
  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, en_cnt = 0, cyc = 0;
  logic [31:0] exp_addr = '0;
  logic addr_bad = 1'b0, auto_done = 1'b1, done_req = 1'b0;
  int dly = 0;

  // memory model with periodic request stalls
  always @(posedge clk) begin
    cyc <= cyc + 1;
    req_ready <= ~cyc[1];
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem[req_addr[9:2]];
      rsp_err   <= req_addr[11];
      req_cnt   <= req_cnt + 1;
      if (req_addr != exp_addr) addr_bad <= 1'b1;
      exp_addr  <= req_addr + 32'd4;
    end
  end

  // channel engine model
  always @(posedge clk) begin
    if (ch_enable) begin
      en_cnt <= en_cnt + 1;
      if (auto_done) dly <= 4;
    end else if (dly != 0) dly <= dly - 1;
    ch_done <= (dly == 1) || done_req;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk);
    req_cnt = 0; addr_bad = 1'b0; exp_addr = a;
    start_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_en(input int target);
    for (int i = 0; i < 400 && en_cnt < target; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    cfg_sel = 5'(idx);
    @(negedge clk);
    v = cfg_data;
  endtask

  task automatic pulse_done();
    @(negedge clk); done_req = 1'b1;
    @(negedge clk); done_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k, en0, words;
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 32; i++) expr[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8 reset state
    chk(!busy && !err && !ch_enable && !req_valid, "R8 reset outputs", {busy, err, ch_enable, req_valid}, 0);
    rd(3, v);
    chk(v == 0 && elem_size == 0 && xfer_mode == 0, "R8 reset register", v, 0);

    // table of header vectors
    for (int n = 0; n < NV; n++) begin
      mem[0] = VHDR[n];
      k = 1;
      if (VHDR[n][0]) for (int r = 0; r < 32; r++) expr[r] = '0;
      for (int b = 0; b < 32; b++) begin
        if (REGS[b] && VHDR[n][b]) begin
          mem[k] = VSEED[n] + 32'(b);
          expr[b] = VSEED[n] + 32'(b);
          k++;
        end
      end
      words = k;
      en0 = en_cnt;
      kick(32'h0);
      wait_en(en0 + 1);
      wait_idle();
      repeat (3) @(negedge clk);
      chk(req_cnt == words, $sformatf("R1 R3 word count hdr %h", VHDR[n]), req_cnt, words);
      chk(!addr_bad, "R2 R9 sequential addresses under stalls", addr_bad, 0);
      chk(en_cnt == en0 + 1, "R5 one enable pulse", en_cnt - en0, 1);
      ok = 1'b1;
      for (int r = 0; r < 32; r++) begin
        rd(r, v);
        if (v != expr[r]) begin
          ok = 1'b0;
          $display("FAIL R1 R4 reg %0d hdr %h actual=%h expected=%h", r, VHDR[n], v, expr[r]);
        end
      end
      chk(ok, "R1 R3 R4 register contents", 0, 0);
    end

    // chaining: R6, R10
    auto_done = 1'b0;
    mem[8'h40] = 32'h4000_0008; mem[8'h41] = 32'h0060_0605; mem[8'h42] = 32'h0000_0203;
    mem[8'h80] = 32'h4000_0008; mem[8'h81] = 32'h0020_0202; mem[8'h82] = 32'h0000_0000;
    en0 = en_cnt;
    kick(32'h100);
    wait_en(en0 + 1);
    chk(req_cnt == 3 && !addr_bad, "R2 first descriptor fetch", req_cnt, 3);
    chk(elem_size == 5 && xfer_mode == 3 && done_mode == 3, "R10 decode fill/cycle",
        {elem_size, xfer_mode, done_mode}, {3'd5, 3'd3, 3'd3});
    repeat (10) @(negedge clk);
    chk(req_cnt == 3 && busy, "R6 no fetch before done", req_cnt, 3);
    pulse_done();
    wait_en(en0 + 2);
    chk(req_cnt == 6 && en_cnt == en0 + 2, "R6 chained to masked link address", req_cnt, 6);
    chk(elem_size == 2 && xfer_mode == 1 && done_mode == 1, "R10 decode continue/cmd",
        {elem_size, xfer_mode, done_mode}, {3'd2, 3'd1, 3'd1});
    pulse_done();
    chk(!busy && req_cnt == 6, "R6 no chain when link bit0 clear", {busy, 7'(req_cnt)}, 6);

    // error on header fetch: R7
    en0 = en_cnt;
    kick(32'h800);
    repeat (4) @(negedge clk);
    wait_idle();
    chk(err && !busy && en_cnt == en0, "R7 header read error", {err, busy}, 2'b10);

    // error mid-descriptor: control loaded earlier must survive
    rd(3, v);
    mem[8'hFF] = 32'h0000_0008;
    kick(32'h7FC);
    repeat (4) @(negedge clk);
    wait_idle();
    begin
      logic [31:0] v2;
      rd(3, v2);
      chk(err && en_cnt == en0 && v2 == v, "R7 payload read error keeps registers", v2, v);
    end

    // restart with empty header clears error and still launches
    mem[0] = 32'h0;
    kick(32'h0);
    wait_en(en0 + 1);
    pulse_done();
    wait_idle();
    chk(!err && en_cnt == en0 + 1 && req_cnt == 1, "R5 R7 empty header after error", {err, 7'(req_cnt)}, 1);

    summary();
    $finish;
  end
endmodule